// File: doc/BRIEF.md
# Page Translation Cache with Access Permission Check

This block is a small, fully associative cache of page translations. A lookup presents a virtual address, a load/store indication and a privilege bit. In the same cycle the block compares the virtual page number against every stored tag. It then returns one of three outcomes:

- a translated physical address with a hit flag,
- a miss flag when no valid entry holds the page, or
- a permission fault when the entry exists but the access is not allowed.

Entries are installed through a refill port, driven by an external table walker or by software. Victims are chosen in first-in, first-out order. A refill whose tag is already present rewrites that entry in place.

Entries carry no process identifier. A context switch therefore uses the flush input, which invalidates every entry at once. The page offset width, address widths and entry count are parameters. The defaults are 32-bit addresses, 4 KB pages (page number in bits 31:12, offset in bits 11:0) and 32 entries.

Top module: `pg_xlate_tlb`

## Requirements
- R1: After reset every entry is invalid, so any requested lookup reports miss=1, hit=0, fault=0.
- R2: A requested lookup whose page number matches a valid entry and whose access is permitted reports hit=1, and lk_pa holds the entry's physical page number in the upper bits. The result is combinational, in the same cycle as the request.
- R3: On a hit, lk_pa[11:0] equals lk_va[11:0] unchanged (default 12-bit offset).
- R4: A requested lookup that matches no valid entry reports miss=1, hit=0, fault=0 and lk_pa=0.
- R5: In user mode (lk_kern=0), a load (lk_store=0) to an entry whose read bit is clear reports fault=1, hit=0, miss=0 and lk_pa=0.
- R6: In user mode, a store (lk_store=1) to an entry whose write bit is clear reports fault=1.
- R7: A store to an entry whose dirty bit is clear reports fault=1 in both user and kernel mode.
- R8: In kernel mode (lk_kern=1), the read and write bits are ignored. A load always hits, and a store hits when the dirty bit is set.
- R9: A refill whose page number equals that of a valid entry rewrites that entry in place. It does not consume a FIFO slot.
- R10: Refills of new page numbers fill slots in FIFO order. Once all DEPTH slots are full, the next new refill evicts the oldest entry.
- R11: A flush pulse invalidates all entries from the next cycle on.
- R12: When flush and refill are asserted in the same cycle, the refill is discarded.
- R13: When lk_req=0, hit, miss and fault are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request valid |
| lk_va | input | VA_W | Virtual address to translate |
| lk_store | input | 1 | 1 = store, 0 = load |
| lk_kern | input | 1 | 1 = kernel mode, 0 = user mode |
| lk_pa | output | PA_W | Translated physical address (0 unless hit) |
| lk_hit | output | 1 | Translation found and access allowed |
| lk_miss | output | 1 | No valid entry for the page |
| lk_fault | output | 1 | Entry found but access refused |
| rf_en | input | 1 | Install an entry this cycle |
| rf_vpn | input | VA_W-OFF_W | Virtual page number to install |
| rf_ppn | input | PA_W-OFF_W | Physical page number to install |
| rf_rd | input | 1 | Read permission of new entry |
| rf_wr | input | 1 | Write permission of new entry |
| rf_dirty | input | 1 | Dirty bit of new entry |
| flush | input | 1 | Invalidate all entries |

## Verification
The bench installs entries covering every combination of the read, write and dirty bits, plus the all-ones page number. It then walks loads and stores in both modes across them. A design that applied the permission bits in kernel mode, or skipped the dirty check there, would show a fault where a hit is expected, or the reverse.

Slot accounting is checked by filling all slots, rewriting an existing tag, and then adding one new page. A design that allocated a fresh slot for the rewrite would evict the second-oldest page instead of the oldest.

Flush is exercised alone and together with a refill in the same cycle. A design that let the refill win would leave a page that still hits.

// File: rtl/tlb_pkg.sv
// Shared types for the page translation cache.
// Assumes the permission check needs only the three per-entry bits below.
package tlb_pkg;

    typedef struct packed {
        logic rd;     // readable in user mode
        logic wr;     // writable in user mode
        logic dirty;  // page already marked modified
    } perm_t;

    // Decide whether an access may use an entry with the given bits
    function automatic logic access_ok(perm_t p, logic is_store, logic is_kern);
        if (is_store && !p.dirty) return 1'b0;
        if (is_kern) return 1'b1;
        return is_store ? p.wr : p.rd;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
// Storage for DEPTH translation entries with parallel tag compare.
// Provides a one-hot lookup match, the selected entry's payload, and
// the index of a valid entry matching the refill tag. Assumes tags of
// valid entries are unique, so the match vectors are at most one-hot.
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn,
    input  perm_t            wr_perm,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic [DEPTH-1:0] lk_match,
    output logic [PPN_W-1:0] lk_ppn,
    output perm_t            lk_perm,
    output logic             rf_any,
    output logic [IDX_W-1:0] rf_idx,
    output logic [DEPTH-1:0] vld_vec
);

    logic [PPN_W-1:0] ppn_arr  [DEPTH];
    perm_t            perm_arr [DEPTH];
    logic [DEPTH-1:0] rf_match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic [VPN_W-1:0] tag_q;
        logic [PPN_W-1:0] ppn_q;
        perm_t            perm_q;
        logic             vld_q;

        // Hold one entry: clear on reset or flush, load on a selected write
        always_ff @(posedge clk) begin
            if (!rst_n || clr_all) begin
                vld_q <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                vld_q  <= 1'b1;
                tag_q  <= wr_vpn;
                ppn_q  <= wr_ppn;
                perm_q <= wr_perm;
            end
        end

        assign lk_match[g] = vld_q && (tag_q == lk_vpn);
        assign rf_match[g] = vld_q && (tag_q == wr_vpn);
        assign vld_vec[g]  = vld_q;
        assign ppn_arr[g]  = ppn_q;
        assign perm_arr[g] = perm_q;
    end

    // OR-select the payload of the (single) matching entry
    always_comb begin
        lk_ppn  = '0;
        lk_perm = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (lk_match[i]) begin
                lk_ppn  = lk_ppn | ppn_arr[i];
                lk_perm = lk_perm | perm_arr[i];
            end
        end
    end

    // Encode the index of the entry already holding the refill tag
    always_comb begin
        rf_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rf_match[i]) rf_idx = rf_idx | IDX_W'(i);
        end
        rf_any = |rf_match;
    end

endmodule

// File: rtl/tlb_fifo_ptr.sv
// Round-robin victim pointer for FIFO replacement.
// Advances by one per new allocation, wraps at DEPTH-1, and returns to
// slot 0 on reset or flush. Assumes DEPTH >= 2.
module tlb_fifo_ptr #(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // Step the pointer on each allocation, wrapping after the last slot
    always_ff @(posedge clk) begin
        if (!rst_n || clr_all) ptr <= '0;
        else if (adv)          ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/pg_xlate_tlb.sv
// Fully associative page translation cache with permission check.
// Lookup is combinational; refill and flush take effect at the next edge.
// Flush wins over refill. A refill of a present tag rewrites it in place.
module pg_xlate_tlb
    import tlb_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int DEPTH = 32,
    localparam int VPN_W = VA_W - OFF_W,
    localparam int PPN_W = PA_W - OFF_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_va,
    input  logic             lk_store,
    input  logic             lk_kern,
    output logic [PA_W-1:0]  lk_pa,
    output logic             lk_hit,
    output logic             lk_miss,
    output logic             lk_fault,
    input  logic             rf_en,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_rd,
    input  logic             rf_wr,
    input  logic             rf_dirty,
    input  logic             flush
);

    logic [DEPTH-1:0] lk_match;
    logic [DEPTH-1:0] vld_vec;
    logic [PPN_W-1:0] sel_ppn;
    perm_t            sel_perm;
    logic             rf_any;
    logic [IDX_W-1:0] rf_idx;
    logic [IDX_W-1:0] ptr;
    logic             wr_en;
    logic             alloc;
    logic [IDX_W-1:0] wr_idx;
    perm_t            wr_perm;
    logic             found;
    logic             allowed;

    assign wr_en   = rf_en && !flush;
    assign alloc   = wr_en && !rf_any;
    assign wr_idx  = rf_any ? rf_idx : ptr;
    assign wr_perm = '{rd: rf_rd, wr: rf_wr, dirty: rf_dirty};

    tlb_entry_array #(
        .DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W)
    ) u_arr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (flush),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (rf_vpn),
        .wr_ppn   (rf_ppn),
        .wr_perm  (wr_perm),
        .lk_vpn   (lk_va[VA_W-1:OFF_W]),
        .lk_match (lk_match),
        .lk_ppn   (sel_ppn),
        .lk_perm  (sel_perm),
        .rf_any   (rf_any),
        .rf_idx   (rf_idx),
        .vld_vec  (vld_vec)
    );

    tlb_fifo_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (flush),
        .adv     (alloc),
        .ptr     (ptr)
    );

    // Classify the lookup and form the physical address
    always_comb begin
        found    = |lk_match;
        allowed  = access_ok(sel_perm, lk_store, lk_kern);
        lk_hit   = lk_req && found && allowed;
        lk_fault = lk_req && found && !allowed;
        lk_miss  = lk_req && !found;
        lk_pa    = lk_hit ? {sel_ppn, lk_va[OFF_W-1:0]} : '0;
    end

endmodule

// File: rtl/pg_xlate_tlb_chk.sv
// Property checker for pg_xlate_tlb, attached by bind below.
module pg_xlate_tlb_chk #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 32,
    parameter int OFF_W = 12,
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_va,
    input logic [PA_W-1:0]  lk_pa,
    input logic             lk_hit,
    input logic             lk_miss,
    input logic             lk_fault,
    input logic             rf_en,
    input logic             flush,
    input logic             rf_any,
    input logic [DEPTH-1:0] lk_match,
    input logic [DEPTH-1:0] vld_vec,
    input logic [IDX_W-1:0] ptr
);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |-> $countones({lk_hit, lk_miss, lk_fault}) == 1); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_hit || lk_miss || lk_fault)); // R13
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_pa[OFF_W-1:0] == lk_va[OFF_W-1:0]); // R3
    AST_MISS_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_miss || lk_fault) |-> lk_pa == '0); // R4
    AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match)); // R9
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> vld_vec == '0); // R11
    AST_REWRITE_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !flush && rf_any) |=> $stable(ptr)); // R9
    AST_ALLOC_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && !flush && !rf_any) |=>
            ptr == (($past(ptr) == IDX_W'(DEPTH - 1)) ? '0 : $past(ptr) + 1'b1)); // R10

endmodule

bind pg_xlate_tlb pg_xlate_tlb_chk #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .DEPTH(DEPTH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_req   (lk_req),
    .lk_va    (lk_va),
    .lk_pa    (lk_pa),
    .lk_hit   (lk_hit),
    .lk_miss  (lk_miss),
    .lk_fault (lk_fault),
    .rf_en    (rf_en),
    .flush    (flush),
    .rf_any   (rf_any),
    .lk_match (lk_match),
    .vld_vec  (vld_vec),
    .ptr      (ptr)
);

// File: tb/sim_pg_xlate_tlb.sv
// Self-checking bench for pg_xlate_tlb with default parameters.
module sim_pg_xlate_tlb;

    localparam int DEPTH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_va = '0;
    logic        lk_store = 1'b0;
    logic        lk_kern = 1'b0;
    logic [31:0] lk_pa;
    logic        lk_hit, lk_miss, lk_fault;
    logic        rf_en = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic        rf_rd = 1'b0, rf_wr = 1'b0, rf_dirty = 1'b0;
    logic        flush = 1'b0;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    pg_xlate_tlb u0 (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_va(lk_va),
        .lk_store(lk_store), .lk_kern(lk_kern), .lk_pa(lk_pa),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .rf_en(rf_en), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_rd(rf_rd),
        .rf_wr(rf_wr), .rf_dirty(rf_dirty), .flush(flush)
    );

    // Vector fields: va[68:37] store[36] kern[35] hit[34] miss[33] fault[32] pa[31:0]
    localparam int NV = 16;
    localparam logic [68:0] VEC [NV] = '{
        {32'h00010ABC, 1'b0, 1'b0, 3'b100, 32'h00A00ABC}, // R2 R3 user load rwd
        {32'h00010123, 1'b1, 1'b0, 3'b100, 32'h00A00123}, // R2 user store rwd
        {32'h00020FFF, 1'b0, 1'b0, 3'b100, 32'h00B00FFF}, // R3 user load r only
        {32'h00020000, 1'b1, 1'b0, 3'b001, 32'h00000000}, // R6 user store no w
        {32'h00030555, 1'b0, 1'b0, 3'b001, 32'h00000000}, // R5 user load no r
        {32'h00030555, 1'b1, 1'b0, 3'b100, 32'h00C00555}, // R6 user store w+d
        {32'h00030555, 1'b0, 1'b1, 3'b100, 32'h00C00555}, // R8 kernel load no r
        {32'h00040777, 1'b1, 1'b0, 3'b001, 32'h00000000}, // R7 user store clean
        {32'h00040777, 1'b1, 1'b1, 3'b001, 32'h00000000}, // R7 kernel store clean
        {32'h00040777, 1'b0, 1'b0, 3'b100, 32'h00D00777}, // R2 user load clean
        {32'h00050000, 1'b0, 1'b0, 3'b010, 32'h00000000}, // R4 absent page
        {32'hFFFFF001, 1'b0, 1'b0, 3'b100, 32'hFFFFF001}, // R3 all-ones page
        {32'h00060010, 1'b1, 1'b1, 3'b100, 32'h00E00010}, // R8 kernel store no w
        {32'h00060010, 1'b1, 1'b0, 3'b001, 32'h00000000}, // R6 user store no w
        {32'h00060010, 1'b0, 1'b1, 3'b100, 32'h00E00010}, // R8 kernel load no r
        {32'h00020FFF, 1'b1, 1'b1, 3'b001, 32'h00000000}  // R7 kernel store clean
    };

    // Compare one lookup result against its expectation
    task automatic check(string req, logic [34:0] exp);
        logic [34:0] act;
        act = {lk_hit, lk_miss, lk_fault, lk_pa};
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got hmf=%b pa=%h, expected hmf=%b pa=%h",
                     req, act[34:32], act[31:0], exp[34:32], exp[31:0]);
        end
    endtask

    // Install one entry over a single clock edge
    task automatic refill(logic [19:0] vpn, logic [19:0] ppn, logic r, logic w, logic d);
        @(negedge clk);
        rf_en = 1'b1; rf_vpn = vpn; rf_ppn = ppn; rf_rd = r; rf_wr = w; rf_dirty = d;
        @(negedge clk);
        rf_en = 1'b0;
    endtask

    // Apply a lookup and compare away from the clock edge
    task automatic look(logic [31:0] va, logic st, logic kn, string req, logic [34:0] exp);
        @(negedge clk);
        lk_req = 1'b1; lk_va = va; lk_store = st; lk_kern = kn;
        #2;
        check(req, exp);
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(32'h00010ABC, 1'b0, 1'b0, "R1 reset empty", {3'b010, 32'h0});
        // R13: no request, no flags
        @(negedge clk);
        lk_req = 1'b0;
        #2;
        check("R13 idle", {3'b000, 32'h0});

        refill(20'h00010, 20'h00A00, 1'b1, 1'b1, 1'b1);
        refill(20'h00020, 20'h00B00, 1'b1, 1'b0, 1'b0);
        refill(20'h00030, 20'h00C00, 1'b0, 1'b1, 1'b1);
        refill(20'h00040, 20'h00D00, 1'b1, 1'b1, 1'b0);
        refill(20'hFFFFF, 20'hFFFFF, 1'b1, 1'b1, 1'b1);
        refill(20'h00060, 20'h00E00, 1'b0, 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            look(VEC[i][68:37], VEC[i][36], VEC[i][35], $sformatf("vector %0d", i), VEC[i][34:0]);
        end

        // R11: flush empties everything
        @(negedge clk);
        lk_req = 1'b0;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        look(32'h00010ABC, 1'b0, 1'b0, "R11 flushed", {3'b010, 32'h0});
        look(32'hFFFFF001, 1'b0, 1'b1, "R11 flushed", {3'b010, 32'h0});

        // R10: fill every slot with new pages
        for (int i = 0; i < DEPTH; i++) begin
            refill(20'h00100 + 20'(i), 20'h01000 + 20'(i), 1'b1, 1'b1, 1'b1);
        end
        look(32'h00100004, 1'b0, 1'b0, "R10 first slot", {3'b100, 32'h01000004});
        look(32'h0011F008, 1'b0, 1'b0, "R10 last slot", {3'b100, 32'h0101F008});

        // R9: rewrite an existing tag with new translation and rights
        refill(20'h00100, 20'h05555, 1'b0, 1'b1, 1'b1);
        look(32'h00100004, 1'b0, 1'b1, "R9 rewritten", {3'b100, 32'h05555004});
        look(32'h00100004, 1'b0, 1'b0, "R9 new rights", {3'b001, 32'h0});

        // R10/R9: one new page evicts the oldest, not the second oldest
        refill(20'h00200, 20'h02000, 1'b1, 1'b1, 1'b1);
        look(32'h00200010, 1'b0, 1'b0, "R10 new page", {3'b100, 32'h02000010});
        look(32'h00100004, 1'b0, 1'b0, "R10 oldest evicted", {3'b010, 32'h0});
        look(32'h00101004, 1'b0, 1'b0, "R9 no slot used", {3'b100, 32'h01001004});

        // R12: flush and refill together drop the refill
        @(negedge clk);
        lk_req = 1'b0;
        flush = 1'b1;
        rf_en = 1'b1; rf_vpn = 20'h00300; rf_ppn = 20'h03000;
        rf_rd = 1'b1; rf_wr = 1'b1; rf_dirty = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        rf_en = 1'b0;
        look(32'h00300000, 1'b0, 1'b0, "R12 refill dropped", {3'b010, 32'h0});
        look(32'h00101004, 1'b0, 1'b0, "R12 flush applied", {3'b010, 32'h0});

        @(negedge clk);
        lk_req = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule